// File: doc/BRIEF.md
# Display Controller Interrupt Unit

This block gathers the four interrupt sources of a display controller into one place. Each source sets a sticky status bit. The sources are a DMA-master bus error, a vertical-timing compare, a frame base-address update and a pixel FIFO underflow. A per-source enable mask gates each status bit onto its own registered, active-high interrupt line. A fifth line is the OR of the four masked lines. This lets software use either one shared service routine or a separate driver for each source.

Software uses a small register port with four word addresses. Address 0 holds the enable mask. Address 1 holds the compare region select. Address 2 holds the raw status, which is cleared by writing a 1 to a bit. Address 3 holds the masked status and is read-only.

The block also owns the DMA master's sequencing state. A bus error parks the master in a held error state. The master stays there until software clears the bus-error status bit. It then returns to frame start, ready to fetch a fresh frame. The timing generator, DMA engine, FIFOs and bus fabric are not part of this block. They appear only as input strobes.

Top module: `disp_irq_unit`

## Requirements
- R1: Status bit positions are fixed. Bit 0 is bus error, bit 1 is vertical compare, bit 2 is base-address update and bit 3 is FIFO underflow. A source strobe that is high at a rising clock edge sets its bit, and the bit stays set after the strobe drops.
- R2: A write to address 2 clears each status bit whose write-data bit is 1. Write-data bits that are 0 leave their status bits unchanged.
- R3: When a set strobe and a write-1 clear reach the same status bit in the same cycle, the bit ends up set.
- R4: A write to address 0 loads the enable mask from write-data bits [3:0], in the same bit order as status. Each individual interrupt output equals its status bit ANDed with its enable bit, one clock after that status and enable value.
- R5: The combined interrupt output is high exactly when at least one of the four individual interrupt outputs is high.
- R6: A write to address 1 loads a 2-bit region select from write-data bits [1:0]. The values are 0 for vertical sync, 1 for back porch, 2 for active video and 3 for front porch. Only the region-start strobe bit picked by the select sets status bit 1. Strobes for the other regions are ignored.
- R7: A base-register transfer strobe from either the upper panel or the lower panel sets status bit 2.
- R8: An underflow pulse from either the upper-panel FIFO or the lower-panel FIFO sets status bit 3.
- R9: A bus error moves the master state output to 2 (error) from any state. The master holds state 2 whatever the fetch and frame strobes do, until the clear described in R10.
- R10: In the error state, a write that clears status bit 0, with no new bus error in the same cycle, returns the master to state 0 (frame start). From state 0, a fetch-start strobe moves it to state 1 (fetching). From state 1, a frame-done strobe moves it back to state 0.
- R11: Synchronous reset clears all status bits, the enable mask, the region select, every interrupt output and the read data, and puts the master in state 0.
- R12: Read data is registered. One clock after an address is presented, the read data shows that address's contents, zero-extended. Address 3 returns status ANDed with enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Registered read data |
| bus_err_i | input | 1 | ERROR response seen by the DMA master |
| fetch_start_i | input | 1 | Master begins a frame fetch |
| frame_done_i | input | 1 | Master finished the frame fetch |
| region_start_i | input | 4 | Region-start strobes: bit 0 vsync, bit 1 back porch, bit 2 active video, bit 3 front porch |
| upper_base_xfer_i | input | 1 | Upper-panel base copied into its current-address counter |
| lower_base_xfer_i | input | 1 | Lower-panel base copied into its current-address counter |
| upper_fifo_uf_i | input | 1 | Upper-panel FIFO read while empty |
| lower_fifo_uf_i | input | 1 | Lower-panel FIFO read while empty |
| irq_bus_err_o | output | 1 | Masked bus-error interrupt |
| irq_vcomp_o | output | 1 | Masked vertical-compare interrupt |
| irq_base_o | output | 1 | Masked base-update interrupt |
| irq_underflow_o | output | 1 | Masked underflow interrupt |
| irq_any_o | output | 1 | Combined interrupt |
| mst_state_o | output | 2 | Master state: 0 frame start, 1 fetching, 2 error |

## Verification
The hardest case to reach from the ports is a clear and a set arriving on the same bit in the same cycle. The nastiest form is a bus error in the same cycle as the write that releases the error state: the status bit must stay set and the master must stay in error. Random stimulus makes bus errors rare and sends roughly a quarter of writes to the status address, with random data. Over a long run this lines up same-cycle clears against every source, including the error-release collision. Directed steps also force the collision on the underflow bit, and they force a release after a held error survives fetch and frame strobes.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
  localparam int NSRC = 4;
  localparam int SRC_BUS_ERR = 0;
  localparam int SRC_VCOMP   = 1;
  localparam int SRC_BASE    = 2;
  localparam int SRC_UFLOW   = 3;

  localparam int NREGION = 4;
  localparam int SELW    = $clog2(NREGION);

  localparam logic [1:0] ADDR_ENABLE = 2'd0;
  localparam logic [1:0] ADDR_CTRL   = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;
  localparam logic [1:0] ADDR_MASKED = 2'd3;

  typedef enum logic [1:0] {
    MST_FRAME = 2'd0,
    MST_FETCH = 2'd1,
    MST_ERROR = 2'd2
  } mst_state_t;
endpackage

// File: rtl/disp_irq_stat_bit.sv
module disp_irq_stat_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end

  assign q_o = q;

  a_r3_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o);
  a_r2_clear_takes: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q_o);
  a_r1_sticky: assert property (@(posedge clk) disable iff (rst)
    (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/disp_irq_vsel.sv
module disp_irq_vsel
  import disp_irq_pkg::*;
#(
  parameter int N  = NREGION,
  parameter int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  region_i,
  input  logic [SW-1:0] sel_i,
  output logic          hit_o
);
  always_comb begin
    hit_o = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (sel_i == SW'(k)) hit_o = region_i[k];
    end
  end
endmodule

// File: rtl/disp_irq_master.sv
module disp_irq_master
  import disp_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_err_i,
  input  logic       release_i,
  input  logic       fetch_start_i,
  input  logic       frame_done_i,
  output logic [1:0] state_o
);
  mst_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MST_FRAME: if (bus_err_i) state_d = MST_ERROR;
                 else if (fetch_start_i) state_d = MST_FETCH;
      MST_FETCH: if (bus_err_i) state_d = MST_ERROR;
                 else if (frame_done_i) state_d = MST_FRAME;
      MST_ERROR: if (release_i && !bus_err_i) state_d = MST_FRAME;
      default:   state_d = MST_FRAME;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= MST_FRAME;
    else     state_q <= state_d;
  end

  assign state_o = state_q;

  a_r9_enter_error: assert property (@(posedge clk) disable iff (rst)
    bus_err_i |=> (state_o == MST_ERROR));
  a_r9_hold_error: assert property (@(posedge clk) disable iff (rst)
    (state_o == MST_ERROR && !release_i) |=> (state_o == MST_ERROR));
  a_r10_release: assert property (@(posedge clk) disable iff (rst)
    (state_o == MST_ERROR && release_i && !bus_err_i) |=> (state_o == MST_FRAME));
  a_r10_legal_code: assert property (@(posedge clk) disable iff (rst)
    state_o != 2'd3);
endmodule

// File: rtl/disp_irq_regs.sv
module disp_irq_regs
  import disp_irq_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [NSRC-1:0] status_i,
  output logic [DW-1:0]   rdata_o,
  output logic [NSRC-1:0] enable_o,
  output logic [SELW-1:0] sel_o,
  output logic [NSRC-1:0] clr_o
);
  logic [NSRC-1:0] en_q;
  logic [SELW-1:0] sel_q;
  logic [DW-1:0]   rd_q;
  logic [DW-1:0]   rd_d;
  logic [1:0]      word;

  assign word = addr_i[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      sel_q <= '0;
    end else if (wr_i) begin
      if (word == ADDR_ENABLE) en_q  <= wdata_i[NSRC-1:0];
      if (word == ADDR_CTRL)   sel_q <= wdata_i[SELW-1:0];
    end
  end

  assign clr_o = (wr_i && word == ADDR_STATUS) ? wdata_i[NSRC-1:0] : '0;

  always_comb begin
    rd_d = '0;
    unique case (word)
      ADDR_ENABLE: rd_d[NSRC-1:0] = en_q;
      ADDR_CTRL:   rd_d[SELW-1:0] = sel_q;
      ADDR_STATUS: rd_d[NSRC-1:0] = status_i;
      default:     rd_d[NSRC-1:0] = status_i & en_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_d;
  end

  assign rdata_o  = rd_q;
  assign enable_o = en_q;
  assign sel_o    = sel_q;

  a_r12_masked_read: assert property (@(posedge clk) disable iff (rst)
    (word == ADDR_MASKED) |=> (rdata_o[NSRC-1:0] == $past(status_i & en_q)));
  a_r4_enable_load: assert property (@(posedge clk) disable iff (rst)
    (wr_i && word == ADDR_ENABLE) |=> (enable_o == $past(wdata_i[NSRC-1:0])));
endmodule

// File: rtl/disp_irq_unit.sv
module disp_irq_unit
  import disp_irq_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          bus_err_i,
  input  logic          fetch_start_i,
  input  logic          frame_done_i,
  input  logic [3:0]    region_start_i,
  input  logic          upper_base_xfer_i,
  input  logic          lower_base_xfer_i,
  input  logic          upper_fifo_uf_i,
  input  logic          lower_fifo_uf_i,
  output logic          irq_bus_err_o,
  output logic          irq_vcomp_o,
  output logic          irq_base_o,
  output logic          irq_underflow_o,
  output logic          irq_any_o,
  output logic [1:0]    mst_state_o
);
  logic [NSRC-1:0] set_v, clr_v, status_v, enable_v;
  logic [SELW-1:0] sel_v;
  logic            vcomp_hit;
  logic [NSRC-1:0] irq_q;
  logic            any_q;

  disp_irq_vsel #(.N(NREGION), .SW(SELW)) u_vsel (
    .region_i (region_start_i),
    .sel_i    (sel_v),
    .hit_o    (vcomp_hit)
  );

  always_comb begin
    set_v              = '0;
    set_v[SRC_BUS_ERR] = bus_err_i;
    set_v[SRC_VCOMP]   = vcomp_hit;
    set_v[SRC_BASE]    = upper_base_xfer_i | lower_base_xfer_i;
    set_v[SRC_UFLOW]   = upper_fifo_uf_i | lower_fifo_uf_i;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_stat
    disp_irq_stat_bit u_bit (
      .clk   (clk),
      .rst   (rst),
      .set_i (set_v[g]),
      .clr_i (clr_v[g]),
      .q_o   (status_v[g])
    );
  end

  disp_irq_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .status_i (status_v),
    .rdata_o  (reg_rdata_o),
    .enable_o (enable_v),
    .sel_o    (sel_v),
    .clr_o    (clr_v)
  );

  disp_irq_master u_master (
    .clk           (clk),
    .rst           (rst),
    .bus_err_i     (bus_err_i),
    .release_i     (clr_v[SRC_BUS_ERR]),
    .fetch_start_i (fetch_start_i),
    .frame_done_i  (frame_done_i),
    .state_o       (mst_state_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= '0;
      any_q <= 1'b0;
    end else begin
      irq_q <= status_v & enable_v;
      any_q <= |(status_v & enable_v);
    end
  end

  assign irq_bus_err_o   = irq_q[SRC_BUS_ERR];
  assign irq_vcomp_o     = irq_q[SRC_VCOMP];
  assign irq_base_o      = irq_q[SRC_BASE];
  assign irq_underflow_o = irq_q[SRC_UFLOW];
  assign irq_any_o       = any_q;

  a_r4_masked_lines: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ({irq_underflow_o, irq_base_o, irq_vcomp_o, irq_bus_err_o}
              == $past(status_v & enable_v)));
  a_r5_combined: assert property (@(posedge clk) disable iff (rst)
    irq_any_o == (irq_bus_err_o | irq_vcomp_o | irq_base_o | irq_underflow_o));
  a_r6_region_ignored: assert property (@(posedge clk) disable iff (rst)
    (!region_start_i[sel_v] && !status_v[SRC_VCOMP]) |=> !status_v[SRC_VCOMP]);
endmodule

// File: tb/disp_irq_unit_bench.sv
module disp_irq_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          reg_wr = 0;
  logic [1:0]    reg_addr = 0;
  logic [DW-1:0] reg_wdata = 0;
  logic [DW-1:0] reg_rdata;
  logic bus_err = 0, fetch_start = 0, frame_done = 0;
  logic [3:0] region = 0;
  logic ub_x = 0, lb_x = 0, u_uf = 0, l_uf = 0;
  logic irq_be, irq_vc, irq_bs, irq_uf, irq_any;
  logic [1:0] mst_state;

  disp_irq_unit u_disp_irq_unit (
    .clk(clk), .rst(rst), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .bus_err_i(bus_err),
    .fetch_start_i(fetch_start), .frame_done_i(frame_done),
    .region_start_i(region), .upper_base_xfer_i(ub_x), .lower_base_xfer_i(lb_x),
    .upper_fifo_uf_i(u_uf), .lower_fifo_uf_i(l_uf), .irq_bus_err_o(irq_be),
    .irq_vcomp_o(irq_vc), .irq_base_o(irq_bs), .irq_underflow_o(irq_uf),
    .irq_any_o(irq_any), .mst_state_o(mst_state)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [3:0] m_st = 0, m_en = 0;
  logic [1:0] m_sel = 0, m_fsm = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_model(input logic [1:0] a, input logic [3:0] st,
                                          input logic [3:0] en, input logic [1:0] sel);
    case (a)
      2'd0: return {4'b0, en};
      2'd1: return {6'b0, sel};
      2'd2: return {4'b0, st};
      default: return {4'b0, st & en};
    endcase
  endfunction

  function automatic logic [1:0] fsm_model(input logic [1:0] s, input logic be,
                                           input logic rel, input logic fs, input logic fd);
    if (s == 2'd2) return (rel && !be) ? 2'd0 : 2'd2;
    if (be) return 2'd2;
    if (s == 2'd0) return fs ? 2'd1 : 2'd0;
    return fd ? 2'd0 : 2'd1;
  endfunction

  task automatic step();
    logic [3:0] o_st, o_en, clr, set;
    logic [1:0] o_sel, o_addr;
    o_st = m_st; o_en = m_en; o_sel = m_sel; o_addr = reg_addr;
    @(posedge clk);
    clr = (reg_wr && reg_addr == 2'd2) ? reg_wdata[3:0] : 4'b0;
    set = {u_uf | l_uf, ub_x | lb_x, region[o_sel], bus_err};
    m_st = (o_st & ~clr) | set;
    if (reg_wr && reg_addr == 2'd0) m_en = reg_wdata[3:0];
    if (reg_wr && reg_addr == 2'd1) m_sel = reg_wdata[1:0];
    m_fsm = fsm_model(m_fsm, bus_err, clr[0], fetch_start, frame_done);
    @(negedge clk);
    chk("R4 masked lines", {irq_uf, irq_bs, irq_vc, irq_be}, o_st & o_en);
    chk("R5 combined", irq_any, |(o_st & o_en));
    chk("R12 read data", reg_rdata, rd_model(o_addr, o_st, o_en, o_sel));
    chk("R9 R10 master state", mst_state, m_fsm);
    reg_wr = 0; bus_err = 0; fetch_start = 0; frame_done = 0; region = 0;
    ub_x = 0; lb_x = 0; u_uf = 0; l_uf = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; step();
  endtask

  task automatic rd_check(input logic [1:0] a, input logic [7:0] exp, input string tag);
    reg_addr = a; step(); chk(tag, reg_rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("R11 reset irq", {irq_any, irq_uf, irq_bs, irq_vc, irq_be}, 0);
    chk("R11 reset state", mst_state, 0);
    chk("R11 reset rdata", reg_rdata, 0);
    rst = 0;
    rd_check(2'd0, 8'h00, "R11 enable zero");

    lb_x = 1; step();
    rd_check(2'd2, 8'h04, "R7 lower base sets bit2");
    wr(2'd2, 8'h04);
    rd_check(2'd2, 8'h00, "R2 clear bit2");
    ub_x = 1; step();
    rd_check(2'd2, 8'h04, "R7 upper base sets bit2");
    wr(2'd2, 8'h04);
    u_uf = 1; step();
    wr(2'd2, 8'h00);
    rd_check(2'd2, 8'h08, "R2 zero write no effect");
    l_uf = 1; reg_wr = 1; reg_addr = 2'd2; reg_wdata = 8'h08; step();
    rd_check(2'd2, 8'h08, "R3 set beats clear, R8 lower uf");
    wr(2'd2, 8'h08);
    rd_check(2'd2, 8'h00, "R2 clear bit3");

    wr(2'd1, 8'h02);
    region = 4'b1011; step();
    rd_check(2'd2, 8'h00, "R6 other regions ignored");
    region = 4'b0100; step();
    rd_check(2'd2, 8'h02, "R6 selected region sets bit1");
    rd_check(2'd1, 8'h02, "R6 select readback");

    wr(2'd0, 8'h02);
    step();
    chk("R4 vcomp line", irq_vc, 1'b1);
    chk("R4 masked bus err", irq_be, 1'b0);
    rd_check(2'd3, 8'h02, "R12 masked status");

    fetch_start = 1; step();
    chk("R10 fetching", mst_state, 2'd1);
    bus_err = 1; step();
    chk("R9 error entered", mst_state, 2'd2);
    chk("R1 bus err no irq when masked", irq_be, 1'b0);
    frame_done = 1; fetch_start = 1; step();
    chk("R9 error held", mst_state, 2'd2);
    bus_err = 1; reg_wr = 1; reg_addr = 2'd2; reg_wdata = 8'h01; step();
    chk("R9 collision stays error", mst_state, 2'd2);
    wr(2'd2, 8'h01);
    chk("R10 released to frame start", mst_state, 2'd0);
    rd_check(2'd2, 8'h02, "R1 bit0 cleared, bit1 kept");

    for (int i = 0; i < 3000; i++) begin
      bus_err     = ($urandom % 16) == 0;
      fetch_start = ($urandom % 3) == 0;
      frame_done  = ($urandom % 3) == 0;
      for (int b = 0; b < 4; b++) region[b] = ($urandom % 4) == 0;
      ub_x = ($urandom % 8) == 0;  lb_x = ($urandom % 8) == 0;
      u_uf = ($urandom % 10) == 0; l_uf = ($urandom % 10) == 0;
      reg_wr    = ($urandom % 4) == 0;
      reg_addr  = 2'($urandom);
      reg_wdata = 8'($urandom);
      step();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule